// File: doc/BRIEF.md
# Memory Bit Field Extractor

This block reads a bit field of 1 to 32 bits from byte-addressed memory and returns it right-justified in a 32-bit word. The caller gives a byte base address, a signed 32-bit bit offset and a 5-bit width code. Bits are numbered from the most significant bit of the base byte, and the count runs towards higher addresses. A negative offset therefore reaches into bytes below the base. A field can cover as many as five bytes.

A one-cycle start pulse captures the operands. The block works out the first byte and the bit position inside it. It then reads the bytes it needs, one per beat, at increasing addresses over a valid/ready read port. The read port returns data in the same cycle as the beat. When the last byte has arrived, the block extracts the field, zero-extends or sign-extends it, and pulses done for one cycle. The result stays on the output until the next operation finishes.

Top module: `bitfield_fetch`

## Requirements
- R1: After reset, rd_valid_o, done_o and busy_o are all low.
- R2: The first read address is base_addr_i plus the offset shifted arithmetically right by 3, modulo 2^32. A negative offset therefore reads from below the base.
- R3: Bit offset b refers to bit (7 - (b mod 8)) of the byte at base + floor(b/8), with bit 7 as the MSB. Offset 0 is the MSB of the base byte, offset 7 is its LSB, and offset -1 is the LSB of the byte below the base. The field is the width bits starting at the offset, with the leftmost bit most significant in the result.
- R4: Exactly ceil(((offset mod 8) + width) / 8) bytes are read, which is 1 to 5. They are read at consecutive increasing addresses, one per beat where rd_valid_o and rd_ready_i are both high.
- R5: A width code of 0 selects a 32-bit field. Codes 1 to 31 select that many bits.
- R6: With sign_ext_i low at start, result bits at and above the width are 0.
- R7: With sign_ext_i high at start, result bits at and above the width copy the leftmost bit of the field.
- R8: While rd_valid_o is high and rd_ready_i is low, the next cycle keeps rd_valid_o high and rd_addr_o unchanged.
- R9: A start pulse while busy_o is high is ignored, and the running operation returns its own result.
- R10: done_o is high for exactly one cycle per operation, and result_o holds its value until the next operation completes.
- R11: Offsets at the extremes of the signed 32-bit range (-2^31 and 2^31-1) are handled with the same address and bit rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request that captures the operands |
| base_addr_i | input | ADDR_W | Byte base address |
| offset_i | input | 32 | Signed bit offset from the MSB of the base byte |
| width_i | input | 5 | Field width code (0 means 32) |
| sign_ext_i | input | 1 | 1 selects sign extension, 0 selects zero extension |
| busy_o | output | 1 | High while an operation is in progress |
| rd_valid_o | output | 1 | Byte read request |
| rd_addr_o | output | ADDR_W | Byte read address |
| rd_ready_i | input | 1 | Read accepted; rd_data_i is valid in this cycle |
| rd_data_i | input | 8 | Read byte |
| done_o | output | 1 | One-cycle completion strobe |
| result_o | output | 32 | Right-justified extended field |

## Verification
The assertions assume the responder never takes back a beat: rd_data_i must be valid in any cycle where rd_valid_o and rd_ready_i are both high. They also assume start_i is only sampled as a one-cycle pulse, with the operands steady in that cycle. The bench meets both by deriving rd_data_i combinationally from rd_addr_o through a fixed address hash. It drives start_i and the operands for one full clock. It changes rd_ready_i a little after each rising edge from a pseudo-random stall pattern. Offsets are swept over -20 to 20 with every width code in both extension modes, and the extreme offsets are added on base addresses that wrap.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  localparam int WIN_BYTES = 5;
  localparam int WIN_W     = WIN_BYTES * 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_DONE  = 2'd2
  } bfx_state_e;
endpackage

// File: rtl/bfx_plan.sv
module bfx_plan #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [31:0]       offset_i,
  input  logic [4:0]        width_code_i,
  output logic [ADDR_W-1:0] start_addr_o,
  output logic [2:0]        start_bit_o,
  output logic [5:0]        width_o,
  output logic [2:0]        nbytes_o
);
  localparam int EXT_W = ADDR_W - 29;

  logic [5:0] span;
  logic [5:0] rounded;

  // byte step is floor(offset / 8), sign-extended to the address width
  assign start_addr_o = base_i + {{EXT_W{offset_i[31]}}, offset_i[31:3]};
  assign start_bit_o  = offset_i[2:0];
  assign width_o      = (width_code_i == 5'd0) ? 6'd32 : {1'b0, width_code_i};
  assign span         = {3'b000, start_bit_o} + width_o;
  assign rounded      = span + 6'd7;
  assign nbytes_o     = rounded[5:3];
endmodule

// File: rtl/bfx_window.sv
module bfx_window #(
  parameter int WIN_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             shift_en_i,
  input  logic [7:0]       byte_i,
  output logic [WIN_W-1:0] win_o
);
  logic [WIN_W-1:0] win_q;
  logic [WIN_W-1:0] win_d;

  always_comb begin
    win_d = win_q;
    if (clr_i) begin
      win_d = '0;
    end else if (shift_en_i) begin
      win_d = {win_q[WIN_W-9:0], byte_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
    end else if (clr_i || shift_en_i) begin
      win_q <= win_d;
    end
  end

  assign win_o = win_q;
endmodule

// File: rtl/bfx_align.sv
module bfx_align #(
  parameter int WIN_W = 40
) (
  input  logic [WIN_W-1:0] win_i,
  input  logic [2:0]       nbytes_i,
  input  logic [2:0]       start_bit_i,
  input  logic [5:0]       width_i,
  input  logic             sext_i,
  output logic [31:0]      result_o
);
  logic [6:0]       rshift;
  logic [WIN_W-1:0] shifted;
  logic [31:0]      low;
  logic [31:0]      mask;
  logic [31:0]      field;
  logic [31:0]      top_bit;

  // bytes sit right-justified in the window, so the field's rightmost bit
  // lies at 8*nbytes - start_bit - width
  assign rshift  = {1'b0, nbytes_i, 3'b000} - {4'b0000, start_bit_i} - {1'b0, width_i};
  assign shifted = win_i >> rshift[5:0];
  assign low     = shifted[31:0];
  assign mask    = (width_i[5]) ? 32'hFFFF_FFFF : ((32'h1 << width_i[4:0]) - 32'h1);
  assign field   = low & mask;
  assign top_bit = low >> (width_i - 6'd1);

  always_comb begin
    result_o = field;
    if (sext_i && top_bit[0]) begin
      result_o = field | ~mask;
    end
  end
endmodule

// File: rtl/bitfield_fetch.sv
module bitfield_fetch
  import bfx_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [31:0]       offset_i,
  input  logic [4:0]        width_i,
  input  logic              sign_ext_i,
  output logic              busy_o,
  output logic              rd_valid_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ready_i,
  input  logic [7:0]        rd_data_i,
  output logic              done_o,
  output logic [31:0]       result_o
);
  bfx_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [2:0]        bit_q, nbytes_q, cnt_q, cnt_d;
  logic [5:0]        width_q;
  logic              sext_q;
  logic [31:0]       result_q, result_d;
  logic              done_q;

  logic [ADDR_W-1:0] plan_addr;
  logic [2:0]        plan_bit, plan_nbytes;
  logic [5:0]        plan_width;
  logic [WIN_W-1:0]  win;
  logic [31:0]       aligned;
  logic              load, beat, last;

  bfx_plan #(.ADDR_W(ADDR_W)) u_plan (
    .base_i       (base_addr_i),
    .offset_i     (offset_i),
    .width_code_i (width_i),
    .start_addr_o (plan_addr),
    .start_bit_o  (plan_bit),
    .width_o      (plan_width),
    .nbytes_o     (plan_nbytes)
  );

  bfx_window #(.WIN_W(WIN_W)) u_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (load),
    .shift_en_i (beat),
    .byte_i     (rd_data_i),
    .win_o      (win)
  );

  bfx_align #(.WIN_W(WIN_W)) u_align (
    .win_i       (win),
    .nbytes_i    (nbytes_q),
    .start_bit_i (bit_q),
    .width_i     (width_q),
    .sext_i      (sext_q),
    .result_o    (aligned)
  );

  assign rd_valid_o = (state_q == ST_FETCH);
  assign rd_addr_o  = addr_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign result_o   = result_q;

  assign load = (state_q == ST_IDLE) && start_i;
  assign beat = rd_valid_o && rd_ready_i;
  assign last = beat && (cnt_q == (nbytes_q - 3'd1));

  always_comb begin
    state_d  = state_q;
    addr_d   = addr_q;
    cnt_d    = cnt_q;
    result_d = result_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_FETCH;
          addr_d  = plan_addr;
          cnt_d   = 3'd0;
        end
      end
      ST_FETCH: begin
        if (beat) begin
          addr_d = addr_q + {{(ADDR_W-1){1'b0}}, 1'b1};
          cnt_d  = cnt_q + 3'd1;
        end
        if (last) begin
          state_d = ST_DONE;
        end
      end
      ST_DONE: begin
        result_d = aligned;
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      cnt_q    <= '0;
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      addr_q   <= addr_d;
      cnt_q    <= cnt_d;
      result_q <= result_d;
      done_q   <= (state_q == ST_DONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q    <= '0;
      width_q  <= 6'd1;
      nbytes_q <= 3'd1;
      sext_q   <= 1'b0;
    end else if (load) begin
      bit_q    <= plan_bit;
      width_q  <= plan_width;
      nbytes_q <= plan_nbytes;
      sext_q   <= sign_ext_i;
    end
  end

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_addr_o));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R4
  beat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> (nbytes_q != 3'd0) && (nbytes_q <= 3'd5) && (cnt_q < nbytes_q));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i |=> $stable(width_q) && $stable(bit_q) && $stable(sext_q));

  // R6
  zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !sext_q && (width_q < 6'd32) |-> ((result_o >> width_q) == 32'd0));
endmodule

// File: tb/test_bitfield_fetch.sv
module test_bitfield_fetch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base = '0;
  logic [31:0] offset = '0;
  logic [4:0]  width = '0;
  logic        sext = 1'b0;
  logic        busy, rd_valid, rd_ready, done;
  logic [31:0] rd_addr, result;
  logic [7:0]  rd_data;
  logic [15:0] lfsr = 16'hACE1;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] mem_byte(logic [31:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ a[31:24] ^ 8'h5A;
  endfunction

  assign rd_data = mem_byte(rd_addr);

  initial rd_ready = 1'b1;
  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rd_ready <= (lfsr[2:0] != 3'd0);
  end

  bitfield_fetch #(.ADDR_W(32)) i_bitfield_fetch (
    .clk(clk), .rst_n(rst_n), .start_i(start), .base_addr_i(base),
    .offset_i(offset), .width_i(width), .sign_ext_i(sext), .busy_o(busy),
    .rd_valid_o(rd_valid), .rd_addr_o(rd_addr), .rd_ready_i(rd_ready),
    .rd_data_i(rd_data), .done_o(done), .result_o(result)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_field(logic [31:0] b, logic [31:0] off,
                                            logic [4:0] wc, logic se);
    int w = (wc == 5'd0) ? 32 : int'(wc);
    logic [31:0] r = '0;
    for (int i = 0; i < w; i++) begin
      longint bp = longint'($signed(off)) + longint'(i);
      longint bi = bp >>> 3;
      logic [31:0] a = 32'(longint'(b) + bi);
      logic [7:0] d = mem_byte(a);
      r = {r[30:0], d[7 - int'(bp & 64'sd7)]};
    end
    if (se && w < 32 && r[w-1]) r = r | ~((32'h1 << w) - 32'h1);
    return r;
  endfunction

  task automatic run_op(input logic [31:0] b, input logic [31:0] off,
                        input logic [4:0] wc, input logic se, input bit meddle);
    int w = (wc == 5'd0) ? 32 : int'(wc);
    int exp_n = (int'(off[2:0]) + w + 7) / 8;
    logic [31:0] exp_a = 32'(longint'(b) + (longint'($signed(off)) >>> 3));
    logic [31:0] exp_r = exp_field(b, off, wc, se);
    int beats = 0;
    int guard = 0;
    bit addr_ok = 1;
    logic [31:0] bad_a = '0;
    logic [31:0] want_a = '0;
    @(negedge clk);
    base = b; offset = off; width = wc; sext = se; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && guard < 100) begin
      if (meddle && beats == 0 && busy) begin
        start = 1'b1; offset = off + 32'd13; width = wc + 5'd3; sext = ~se;
        base = b + 32'd7;
      end
      if (rd_valid && rd_ready) begin
        if (rd_addr !== exp_a + 32'(beats)) begin
          addr_ok = 0; bad_a = rd_addr; want_a = exp_a + 32'(beats);
        end
        beats++;
      end
      @(negedge clk);
      start = 1'b0;
      guard++;
    end
    // R2 / R4: start address and increasing consecutive addresses
    check(addr_ok, "R2/R4 read address", bad_a, want_a);
    // R4: byte count
    check(beats == exp_n, "R4 byte count", 32'(beats), 32'(exp_n));
    // R3 R5 R6 R7 R9 R11: extracted value
    check(done && result === exp_r, meddle ? "R9 result" : "R3/R5/R6/R7 result",
          result, exp_r);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!rd_valid && !done && !busy, "R1 reset", {29'd0, rd_valid, done, busy}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!rd_valid && !done && !busy, "R1 after release",
          {29'd0, rd_valid, done, busy}, 32'd0);

    // R3: offsets 0, 7 and -1 single bits
    run_op(32'h0000_1000, 32'd0, 5'd1, 1'b0, 0);
    run_op(32'h0000_1000, 32'd7, 5'd1, 1'b0, 0);
    run_op(32'h0000_1000, 32'hFFFF_FFFF, 5'd1, 1'b0, 0);
    // R5: width code 0 spanning five bytes
    run_op(32'h0000_2003, 32'd5, 5'd0, 1'b0, 0);

    // sweep: R3 R4 R5 R6 R7
    for (int o = -20; o <= 20; o++) begin
      for (int wc = 0; wc < 32; wc++) begin
        for (int s = 0; s < 2; s++) begin
          run_op(32'h0000_3417 + 32'(o * 3), 32'(o), 5'(wc), 1'(s), 0);
        end
      end
    end

    // R11: extreme offsets, with wrapping bases
    run_op(32'h1000_0000, 32'h8000_0000, 5'd0, 1'b1, 0);
    run_op(32'h0000_0005, 32'h8000_0003, 5'd17, 1'b1, 0);
    run_op(32'hF000_0000, 32'h7FFF_FFFF, 5'd9, 1'b0, 0);
    run_op(32'hF000_0000, 32'h7FFF_FFF9, 5'd31, 1'b1, 0);

    // R9: start while busy is ignored
    run_op(32'h0000_5555, 32'd3, 5'd12, 1'b1, 1);
    run_op(32'h0000_0100, 32'hFFFF_FFF1, 5'd0, 1'b0, 1);

    // R10: done lasts one cycle, result holds
    begin
      logic [31:0] held;
      run_op(32'h0000_0777, 32'd11, 5'd20, 1'b1, 0);
      held = result;
      @(negedge clk);
      check(!done, "R10 done one cycle", {31'd0, done}, 32'd0);
      repeat (5) @(negedge clk);
      check(result === held, "R10 result held", result, held);
    end

    // R8: with constant stall the request stays put
    begin
      logic [31:0] a0;
      bit ok = 1;
      @(negedge clk);
      base = 32'h0000_0900; offset = 32'd0; width = 5'd8; sext = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      a0 = rd_addr;
      for (int k = 0; k < 6; k++) begin
        if (rd_valid && !rd_ready) begin
          @(negedge clk);
          if (!rd_valid || rd_addr !== a0) ok = 0;
        end else begin
          @(negedge clk);
        end
        if (rd_valid) a0 = rd_addr;
      end
      check(ok, "R8 stall hold", rd_addr, a0);
      while (busy || done) @(negedge clk);
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule